// File: doc/BRIEF.md
# CPU Clock Burst Power Controller

This block lowers processor power by turning the CPU clock enable on and off in bursts. A burst period has 31 slots. A slow reference clock sets the pace: each rising edge moves a slot counter on by one. A 5-bit width setting gives the number of slots in each period during which the clock runs. The duty cycle can therefore be any value from 0/31 to 31/31. The output is a registered enable that a glitch-free clock gate downstream uses to build the CPU clock.

Software controls the block through a small synchronous register port with three fields: a burst enable bit, a doze bit and the width. Setting either bit turns the controller on. The doze bit does not wait for the burst period to end. It cuts the clock once the bus cycle that completes after the next reference rising edge has finished. The clock stays off until the next burst period starts. An interrupt or wake-up input turns the controller off at once and restores continuous clocking. The width setting is left unchanged, so software only has to set the enable or doze bit again to go back to power saving.

Top module: `cpu_burst_pwr_ctrl`

## Requirements
- R1: After reset `cpu_clk_en_o` is 1, the width reads 31 (5'b11111), and the enable and doze bits read 0.
- R2: While both the enable and doze bits are 0, `cpu_clk_en_o` stays 1 whatever the width and reference activity.
- R3: While the controller is on, one reference rising edge moves the slot index on by one, over 31 slots (0 to 30, then back to 0). Turning the controller on restarts the index at 0. `cpu_clk_en_o` is 1 exactly while slot index < width.
- R4: A width of 31 keeps `cpu_clk_en_o` at 1 in every slot. A width of 0 keeps it at 0 in every slot while the controller is on.
- R5: A width written during a burst period takes effect only from the next period start (slot 0). The current period finishes with the old width.
- R6: Writing 1 to the doze bit (address 0, bit 1) turns the controller on. `cpu_clk_en_o` drops only after a `bus_done_i` strobe that arrives after the next reference rising edge. A strobe before that edge has no effect.
- R7: Once the clock has been cut by the doze bit, it stays off until the next burst period start. After that it follows the width again.
- R8: A cycle with `wake_i` high clears the enable and doze bits, forces `cpu_clk_en_o` to 1 from the next cycle, and keeps the width.
- R9: When `wake_i` and a write to address 0 fall in the same cycle, the wake-up wins and both bits read 0. A width write (address 1) in the same cycle as `wake_i` is still taken.
- R10: Register map. Address 0 holds the enable bit at bit 0 and the doze bit at bit 1; its other read bits are 0. Address 1 holds the width at bits 4:0. Reads are combinational from the selected address.
- R11: Writing 0 to both bits of address 0 turns the controller off: `cpu_clk_en_o` returns to 1 and the width is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_clk_i | input | 1 | Slow reference clock, sampled and edge-detected |
| bus_done_i | input | 1 | One-cycle strobe at the end of a CPU bus cycle |
| wake_i | input | 1 | Interrupt or wake-up event |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 1 | Register address (0 mode, 1 width) |
| reg_wdata_i | input | 5 | Register write data |
| reg_rdata_o | output | 5 | Register read data for `reg_addr_i` |
| cpu_clk_en_o | output | 1 | Registered CPU clock enable |

## Verification
Two events can land on the same clock edge: a software write to the mode register and a wake-up pulse. The bench drives `wake_i` together with a write of the enable bit. It then reads the mode register back and expects 0, with the clock enable at 1 on the next cycle. The bench also pairs a wake-up with a width write and expects the new width to read back. The doze sequence is checked by strobing `bus_done_i` both before and after a reference edge, and the clock enable is sampled after each strobe.

// File: rtl/burst_pwr_pkg.sv
package burst_pwr_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_WAIT_REF = 2'd1,
        SEQ_WAIT_BUS = 2'd2,
        SEQ_DOZE     = 2'd3
    } doze_seq_e;

    localparam int unsigned MODE_EN_BIT   = 0;
    localparam int unsigned MODE_DOZE_BIT = 1;
    localparam logic        ADDR_MODE     = 1'b0;
    localparam logic        ADDR_WIDTH    = 1'b1;

endpackage

// File: rtl/ref_edge_det.sv
module ref_edge_det #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic tick_o
);
    localparam int unsigned DEPTH = SYNC_STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] shreg;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.shreg = {st_q.shreg[DEPTH-2:0], ref_i};
        tick_o     = st_q.shreg[SYNC_STAGES-1] & ~st_q.shreg[SYNC_STAGES];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R3
    single_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/burst_slot_ctr.sv
module burst_slot_ctr #(
    parameter int unsigned WIDTH_W = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               active_i,
    input  logic               tick_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic [WIDTH_W-1:0] slot_d_o,
    output logic [WIDTH_W-1:0] cur_width_d_o,
    output logic               period_start_o
);
    localparam int unsigned    NUM_SLOTS = (1 << WIDTH_W) - 1;
    localparam logic [WIDTH_W-1:0] LAST_SLOT = WIDTH_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic [WIDTH_W-1:0] slot;
        logic [WIDTH_W-1:0] cur_width;
    } slot_state_t;

    slot_state_t st_d, st_q;
    logic        wrap;

    always_comb begin
        st_d = st_q;
        wrap = active_i && tick_i && (st_q.slot == LAST_SLOT);
        if (!active_i) begin
            st_d.slot      = '0;
            st_d.cur_width = width_i;
        end else if (tick_i) begin
            if (wrap) begin
                st_d.slot      = '0;
                st_d.cur_width = width_i;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
        slot_d_o       = st_d.slot;
        cur_width_d_o  = st_d.cur_width;
        period_start_o = wrap;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.slot      <= '0;
            st_q.cur_width <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.slot <= LAST_SLOT);

    // R5
    width_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_i && !wrap) |=> $stable(st_q.cur_width));

endmodule

// File: rtl/doze_seq.sv
module doze_seq
    import burst_pwr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_d_i,
    input  logic arm_i,
    input  logic wake_i,
    input  logic tick_i,
    input  logic bus_done_i,
    input  logic period_start_i,
    output logic doze_d_o
);
    typedef struct packed {
        doze_seq_e seq;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wake_i || !active_d_i) begin
            st_d.seq = SEQ_IDLE;
        end else if (arm_i) begin
            st_d.seq = SEQ_WAIT_REF;
        end else begin
            unique case (st_q.seq)
                SEQ_WAIT_REF: if (tick_i)         st_d.seq = SEQ_WAIT_BUS;
                SEQ_WAIT_BUS: if (bus_done_i)     st_d.seq = SEQ_DOZE;
                SEQ_DOZE:     if (period_start_i) st_d.seq = SEQ_IDLE;
                default:                          st_d.seq = st_q.seq;
            endcase
        end
        doze_d_o = (st_d.seq == SEQ_DOZE);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q.seq <= SEQ_IDLE;
        else         st_q <= st_d;
    end

    // R6
    doze_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.seq == SEQ_DOZE) |-> $past(st_q.seq == SEQ_WAIT_BUS && bus_done_i));

    // R7
    doze_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.seq == SEQ_DOZE && !wake_i && active_d_i && !arm_i && !period_start_i)
        |=> st_q.seq == SEQ_DOZE);

endmodule

// File: rtl/cpu_burst_pwr_ctrl.sv
module cpu_burst_pwr_ctrl
    import burst_pwr_pkg::*;
#(
    parameter int unsigned WIDTH_W     = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               ref_clk_i,
    input  logic               bus_done_i,
    input  logic               wake_i,
    input  logic               reg_we_i,
    input  logic               reg_addr_i,
    input  logic [WIDTH_W-1:0] reg_wdata_i,
    output logic [WIDTH_W-1:0] reg_rdata_o,
    output logic               cpu_clk_en_o
);
    typedef struct packed {
        logic               en;
        logic               doze;
        logic [WIDTH_W-1:0] width;
        logic               clk_en;
    } ctrl_state_t;

    ctrl_state_t        st_d, st_q;
    logic               tick;
    logic               active_q, active_d;
    logic               arm;
    logic               doze_d;
    logic               period_start;
    logic [WIDTH_W-1:0] slot_d, cur_width_d;

    ref_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ref_i (ref_clk_i),
        .tick_o(tick)
    );

    burst_slot_ctr #(.WIDTH_W(WIDTH_W)) i_slots (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .active_i      (active_q),
        .tick_i        (tick),
        .width_i       (st_q.width),
        .slot_d_o      (slot_d),
        .cur_width_d_o (cur_width_d),
        .period_start_o(period_start)
    );

    doze_seq i_doze (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .active_d_i    (active_d),
        .arm_i         (arm),
        .wake_i        (wake_i),
        .tick_i        (tick),
        .bus_done_i    (bus_done_i),
        .period_start_i(period_start),
        .doze_d_o      (doze_d)
    );

    always_comb begin
        st_d = st_q;
        if (reg_we_i && reg_addr_i == ADDR_WIDTH) begin
            st_d.width = reg_wdata_i;
        end
        if (reg_we_i && reg_addr_i == ADDR_MODE) begin
            st_d.en   = reg_wdata_i[MODE_EN_BIT];
            st_d.doze = reg_wdata_i[MODE_DOZE_BIT];
        end
        if (wake_i) begin
            st_d.en   = 1'b0;
            st_d.doze = 1'b0;
        end
        active_q = st_q.en | st_q.doze;
        active_d = st_d.en | st_d.doze;
        arm      = reg_we_i && (reg_addr_i == ADDR_MODE)
                   && reg_wdata_i[MODE_DOZE_BIT] && !wake_i;
        if (!active_d)    st_d.clk_en = 1'b1;
        else if (doze_d)  st_d.clk_en = 1'b0;
        else              st_d.clk_en = (slot_d < cur_width_d);
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_WIDTH) begin
            reg_rdata_o = st_q.width;
        end else begin
            reg_rdata_o[MODE_EN_BIT]   = st_q.en;
            reg_rdata_o[MODE_DOZE_BIT] = st_q.doze;
        end
    end

    assign cpu_clk_en_o = st_q.clk_en;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.en     <= 1'b0;
            st_q.doze   <= 1'b0;
            st_q.width  <= '1;
            st_q.clk_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    wake_clk_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_i |=> cpu_clk_en_o);

    // R9
    wake_clears_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_i |=> (!st_q.en && !st_q.doze));

    // R8
    wake_keeps_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_i && !(reg_we_i && reg_addr_i == ADDR_WIDTH)) |=> $stable(st_q.width));

    // R2
    idle_full_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_q |-> cpu_clk_en_o);

endmodule

// File: tb/test_cpu_burst_pwr_ctrl.sv
module test_cpu_burst_pwr_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 6;
    localparam int  VEC_WIDTH [NVEC] = '{3, 0, 31, 1, 30, 16};
    localparam int  VEC_STEPS [NVEC] = '{8, 4, 4, 33, 32, 20};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic       bus_done = 1'b0;
    logic       wake = 1'b0;
    logic       we = 1'b0;
    logic       addr = 1'b0;
    logic [4:0] wdata = '0;
    logic [4:0] rdata;
    logic       clk_en;
    int         n_chk = 0;
    int         n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_burst_pwr_ctrl i_cpu_burst_pwr_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ref_clk_i   (ref_clk),
        .bus_done_i  (bus_done),
        .wake_i      (wake),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .cpu_clk_en_o(clk_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [4:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic ref_pulse();
        @(negedge clk);
        ref_clk = 1'b1;
        repeat (4) @(negedge clk);
        ref_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_strobe();
        @(negedge clk);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 clk_en", int'(clk_en), 1);
        rd(1'b1, v); check("R1 width", v, 31);
        rd(1'b0, v); check("R1 mode", v, 0);

        // Vector table: R2 (idle), R3/R4 (bursts)
        for (int k = 0; k < NVEC; k++) begin
            wr(1'b0, 5'd0);
            wr(1'b1, 5'(VEC_WIDTH[k]));
            for (int p = 0; p < 2; p++) begin
                ref_pulse();
                check("R2 idle clk_en", int'(clk_en), 1);
            end
            wr(1'b0, 5'd1);
            for (int i = 0; i < VEC_STEPS[k]; i++) begin
                check((VEC_WIDTH[k] == 0 || VEC_WIDTH[k] == 31) ? "R4 burst" : "R3 burst",
                      int'(clk_en), ((i % 31) < VEC_WIDTH[k]) ? 1 : 0);
                ref_pulse();
            end
        end

        // R5 width change mid-period
        wr(1'b0, 5'd0);
        wr(1'b1, 5'd5);
        wr(1'b0, 5'd1);
        ref_pulse(); ref_pulse();
        wr(1'b1, 5'd1);
        check("R5 old width slot2", int'(clk_en), 1);
        ref_pulse(); ref_pulse();
        check("R5 old width slot4", int'(clk_en), 1);
        for (int i = 4; i < 31; i++) ref_pulse();
        check("R5 new width slot0", int'(clk_en), 1);
        ref_pulse();
        check("R5 new width slot1", int'(clk_en), 0);

        // R11 clearing mode keeps width
        wr(1'b0, 5'd0);
        check("R11 clk_en", int'(clk_en), 1);
        rd(1'b1, v); check("R11 width", v, 1);

        // R6 doze sequence
        wr(1'b1, 5'd31);
        wr(1'b0, 5'd2);
        rd(1'b0, v); check("R10 doze bit", v, 2);
        bus_strobe();
        check("R6 early strobe ignored", int'(clk_en), 1);
        ref_pulse();
        check("R6 waits for bus", int'(clk_en), 1);
        bus_strobe();
        check("R6 cut after bus", int'(clk_en), 0);
        // R7 stays off until period start (slot is 1 now)
        for (int i = 0; i < 29; i++) ref_pulse();
        check("R7 off before period start", int'(clk_en), 0);
        ref_pulse();
        check("R7 on at period start", int'(clk_en), 1);

        // R8 wake-up during doze
        wr(1'b0, 5'd2);
        ref_pulse();
        bus_strobe();
        check("R8 dozing", int'(clk_en), 0);
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        check("R8 clk_en after wake", int'(clk_en), 1);
        rd(1'b0, v); check("R8 mode cleared", v, 0);
        rd(1'b1, v); check("R8 width kept", v, 31);

        // R9 wake and mode write together
        @(negedge clk);
        we = 1'b1; addr = 1'b0; wdata = 5'd1; wake = 1'b1;
        @(negedge clk);
        we = 1'b0; wake = 1'b0;
        rd(1'b0, v); check("R9 mode write lost", v, 0);
        check("R9 clk_en", int'(clk_en), 1);
        // R9 wake and width write together
        @(negedge clk);
        we = 1'b1; addr = 1'b1; wdata = 5'd7; wake = 1'b1;
        @(negedge clk);
        we = 1'b0; wake = 1'b0;
        rd(1'b1, v); check("R9 width write taken", v, 7);

        // R10 enable bit readback
        wr(1'b0, 5'd1);
        rd(1'b0, v); check("R10 enable bit", v, 1);
        wr(1'b0, 5'd0);

        // R1 reset again restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(1'b1, v); check("R1 width after reset", v, 31);
        check("R1 clk_en after reset", int'(clk_en), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule